// File: doc/BRIEF.md
# Stereo serial audio transmitter

This block sends a stereo pair of 24-bit two's-complement samples over a single serial data line. Its timing is set by two external framing clocks. The bit clock marks the data slots. The word-select clock splits each frame into a left half and a right half. Both framing clocks are oversampled by a faster core clock. The data output changes a fixed, short number of core cycles after each bit-clock falling edge. It is therefore stable well before the next rising edge, where a receiver samples it.

Two framings are available. In left-justified framing, the most significant bit appears in the first slot of each half. In I2S framing, it appears one slot later. The framing is chosen by a strap on the data pin itself. While reset is held, the pad driver is switched off, so the external pull resistor sets the pin level. That level is captured when the internal reset is released: high selects I2S, low selects left-justified. The pad driver is then switched on.

Any number of bit-clock periods per frame works, as long as each half has at least as many slots as a sample has bits. This covers both the 64-slot and the 48-slot frame.

A parallel sample pair is loaded with a valid strobe at any time. The pair that is held when a new frame begins is the pair that frame transmits.

Top module: `stereo_ser_tx`

## Requirements
- R1: Each sample goes out MSB first, bit 23 down to bit 0, one bit per bit-clock period, unchanged, with the left sample in the left half and the right sample in the right half.
- R2: The format is taken from `sd_pad_in` while reset is in effect and frozen at release: 1 selects I2S, 0 selects left-justified. Later activity on the pin does not change it.
- R3: While reset is in effect, `sd_oe` is 0 and `sd_out` is 0. `sd_oe` becomes 1 within a few core cycles after reset is released.
- R4: Left-justified: the left half is the one with `lrck` = 1. Bit 23 occupies the slot that begins at the bit-clock fall on which `lrck` changes.
- R5: I2S: the left half is the one with `lrck` = 0. Bit 23 occupies the second slot of the half, one bit-clock period after the `lrck` change.
- R6: `sd_out` changes only in response to a bit-clock falling edge, so it holds one value across the whole slot, including the rising edge.
- R7: Every slot of a half that follows the last bit of that half's word is driven to 0.
- R8: In I2S, bit 0 of a word that does not fit in its half is sent in the first slot of the next half. With 24-slot halves (a 48-slot frame), bit 0 goes there. With longer halves, that slot is 0.
- R9: A frame starts at the `lrck` change into the left half. At that point the held pair is captured, and the words being shifted out do not change until the next frame start. A strobe during a frame, or in the same core cycle as its start, takes effect in the next frame.
- R10: If several strobes arrive between two frame starts, the last one is sent. With no strobe, the previous pair is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the framing clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Bit clock; data changes after its falling edge |
| lrck | input | 1 | Word-select clock; changes together with a bit-clock fall |
| smp_left | input | 24 | Left sample, two's complement |
| smp_right | input | 24 | Right sample, two's complement |
| smp_valid | input | 1 | One-cycle strobe that loads the sample pair |
| sd_pad_in | input | 1 | Level seen on the data pad, used as the format strap |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Pad driver enable; 0 during reset |

## Verification
The bench uses the default widths: 24-bit samples, and two-stage synchronizers for the framing clocks and the reset. The bit-clock half period is four core cycles, which just covers the synchronizer and output-register delay. The bench drives both 64-slot and 48-slot frames under each format. This exposes the zero fill of long halves, the I2S carry of bit 0 into the next half, and a change of frame length between frames. A reset is issued with the strap pulled high and again with it pulled low. Strobes are placed mid-frame, and twice in one frame, to show that a pair is captured only at frame start and that the last strobe wins.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic {
    FMT_LJ  = 1'b0,
    FMT_I2S = 1'b1
  } stx_fmt_e;

  // lrck level that marks the left half for a given framing
  function automatic logic left_level(stx_fmt_e f);
    return (f == FMT_LJ) ? 1'b1 : 1'b0;
  endfunction

endpackage

// File: rtl/stx_sync.sv
module stx_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam int TOP = STAGES - 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], din[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign dout[b] = chain_q[TOP];
  end

endmodule

// File: rtl/stx_rst_sync.sv
module stx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);

  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  // asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_int_n = chain_q[TOP];

endmodule

// File: rtl/stx_strap.sv
module stx_strap
  import stx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rst_int_n,
  input  logic     pad_level,
  output stx_fmt_e fmt,
  output logic     pad_oe
);

  stx_fmt_e fmt_q, fmt_d;
  logic     oe_q, oe_d;

  // strap register: follows the pad while in reset, frozen afterwards
  always_comb begin
    fmt_d = fmt_q;
    if (!rst_int_n) fmt_d = stx_fmt_e'(pad_level);
  end

  always_ff @(posedge clk) begin
    fmt_q <= fmt_d;
  end

  always_comb begin
    oe_d = rst_int_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= oe_d;
  end

  assign fmt    = fmt_q;
  assign pad_oe = oe_q;

  assert_fmt_frozen_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_int_n |=> $stable(fmt_q));

  assert_oe_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_int_n) |=> oe_q);

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
  import stx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  stx_fmt_e            fmt,
  input  logic                sclk_lvl,
  input  logic                lrck_lvl,
  input  logic [SAMPLE_W-1:0] smp_l,
  input  logic [SAMPLE_W-1:0] smp_r,
  input  logic                smp_vld,
  output logic                sd
);

  localparam int MSB = SAMPLE_W - 1;

  logic [SAMPLE_W-1:0] pend_l_q, pend_l_d;
  logic [SAMPLE_W-1:0] pend_r_q, pend_r_d;
  logic [SAMPLE_W-1:0] cur_r_q,  cur_r_d;
  logic [SAMPLE_W-1:0] sh_q,     sh_d;
  logic [SAMPLE_W-1:0] load_word;
  logic                sd_q, sd_d;
  logic                sclk_prev_q, lrck_last_q, lrck_last_d;
  logic                sclk_fall, half_start, is_left, frame_start;

  always_comb begin
    sclk_fall   = sclk_prev_q & ~sclk_lvl;
    half_start  = sclk_fall & (lrck_lvl != lrck_last_q);
    is_left     = (lrck_lvl == left_level(fmt));
    frame_start = half_start & is_left;
    load_word   = is_left ? pend_l_q : cur_r_q;
  end

  always_comb begin
    pend_l_d    = pend_l_q;
    pend_r_d    = pend_r_q;
    cur_r_d     = cur_r_q;
    sh_d        = sh_q;
    sd_d        = sd_q;
    lrck_last_d = lrck_last_q;

    if (smp_vld) begin
      pend_l_d = smp_l;
      pend_r_d = smp_r;
    end

    if (sclk_fall) begin
      lrck_last_d = lrck_lvl;
      if (half_start) begin
        if (frame_start) cur_r_d = pend_r_q;
        if (fmt == FMT_LJ) begin
          sd_d = load_word[MSB];
          sh_d = {load_word[MSB-1:0], 1'b0};
        end else begin
          // one-slot delay: leftover bit of the previous half goes first
          sd_d = sh_q[MSB];
          sh_d = load_word;
        end
      end else begin
        sd_d = sh_q[MSB];
        sh_d = {sh_q[MSB-1:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l_q    <= '0;
      pend_r_q    <= '0;
      cur_r_q     <= '0;
      sh_q        <= '0;
      sd_q        <= 1'b0;
      sclk_prev_q <= 1'b0;
      lrck_last_q <= 1'b0;
    end else begin
      pend_l_q    <= pend_l_d;
      pend_r_q    <= pend_r_d;
      cur_r_q     <= cur_r_d;
      sh_q        <= sh_d;
      sd_q        <= sd_d;
      sclk_prev_q <= sclk_lvl;
      lrck_last_q <= lrck_last_d;
    end
  end

  assign sd = sd_q;

  assert_data_only_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(sd_q));

  assert_right_word_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cur_r_q));

  assert_pend_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(pend_l_q) && $stable(pend_r_q));

  assert_zero_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall && !half_start && sh_q == '0) |=> !sd_q);

endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx
  import stx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                lrck,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                smp_valid,
  input  logic                sd_pad_in,
  output logic                sd_out,
  output logic                sd_oe
);

  localparam int NCLK = 2;

  logic            rst_int_n;
  logic [NCLK-1:0] clk_raw, clk_sync;
  stx_fmt_e        fmt;

  assign clk_raw = {lrck, sclk};

  stx_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  stx_sync #(.W(NCLK), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (clk_raw),
    .dout  (clk_sync)
  );

  stx_strap u_strap (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n),
    .pad_level (sd_pad_in),
    .fmt       (fmt),
    .pad_oe    (sd_oe)
  );

  stx_shifter #(.SAMPLE_W(SAMPLE_W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fmt      (fmt),
    .sclk_lvl (clk_sync[0]),
    .lrck_lvl (clk_sync[1]),
    .smp_l    (smp_left),
    .smp_r    (smp_right),
    .smp_vld  (smp_valid),
    .sd       (sd_out)
  );

endmodule

// File: tb/stereo_ser_tx_bench.sv
`timescale 1ns/100ps
module stereo_ser_tx_bench;

  localparam int SW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sclk = 1'b1;
  logic          lrck = 1'b0;
  logic          strap = 1'b1;
  logic          smp_valid = 1'b0;
  logic [SW-1:0] smp_l = '0;
  logic [SW-1:0] smp_r = '0;
  logic          sd_out, sd_oe, pad;

  always #2.5 clk = ~clk;

  assign pad = sd_oe ? sd_out : strap;

  stereo_ser_tx u_stereo_ser_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .lrck      (lrck),
    .smp_left  (smp_l),
    .smp_right (smp_r),
    .smp_valid (smp_valid),
    .sd_pad_in (pad),
    .sd_out    (sd_out),
    .sd_oe     (sd_oe)
  );

  typedef struct {
    logic  bitv;
    string tag;
  } exp_t;

  exp_t          exp_q[$];
  int            n_chk = 0;
  int            n_bad = 0;
  bit            fmt_i2s, mon_en = 0, cur_ok = 0, done = 0;
  logic          cur_bit;
  logic          carry;
  logic [SW-1:0] mod_l, mod_r;

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // monitor: compare at each rising bit-clock edge, recheck at the next fall
  always @(posedge sclk) begin
    if (mon_en) begin
      if (exp_q.size() == 0) begin
        check("R1 (nothing expected)", 1'b1, 1'b0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, sd_out, e.bitv);
        cur_bit = e.bitv;
        cur_ok  = 1;
      end
    end
  end

  always @(negedge sclk) begin
    if (mon_en && cur_ok) check("R6 stable through slot", sd_out, cur_bit);
  end

  task automatic slot(logic lr, bit strobe, logic [SW-1:0] l, logic [SW-1:0] r);
    sclk = 1'b0;
    lrck = lr;
    if (strobe) begin
      smp_l = l; smp_r = r; smp_valid = 1'b1;
      #5 smp_valid = 1'b0;
      #15;
    end else begin
      #20;
    end
    sclk = 1'b1;
    #20;
  endtask

  task automatic do_reset(bit i2s);
    mon_en = 0; cur_ok = 0;
    exp_q.delete();
    strap = i2s;
    sclk = 1'b1;
    lrck = i2s ? 1'b1 : 1'b0;
    #10 rst_n = 1'b0;
    #20;
    check("R3 oe low in reset", sd_oe, 1'b0);
    check("R3 data low in reset", sd_out, 1'b0);
    rst_n = 1'b1;
    #40;
    check("R3 oe high after release", sd_oe, 1'b1);
    fmt_i2s = i2s;
    mod_l = '0; mod_r = '0; carry = 1'b0;
    for (int k = 0; k < 2; k++) slot(i2s ? 1'b1 : 1'b0, 0, '0, '0);
    mon_en = 1;
  endtask

  // driver: push the expected stream of a frame, then generate it
  task automatic frame(int n, string tag, int nstrobe,
                       logic [SW-1:0] l1, logic [SW-1:0] r1,
                       logic [SW-1:0] l2, logic [SW-1:0] r2);
    int   half;
    logic left_lv;
    half    = n / 2;
    left_lv = fmt_i2s ? 1'b0 : 1'b1;
    for (int h = 0; h < 2; h++) begin
      logic [SW-1:0] w;
      w = (h == 0) ? mod_l : mod_r;
      for (int i = 0; i < half; i++) begin
        if (!fmt_i2s) begin
          if (i < SW) exp_q.push_back('{w[SW-1-i], (i == 0) ? "R4 msb first slot" : tag});
          else        exp_q.push_back('{1'b0, "R7 fill"});
        end else begin
          if (i == 0)        exp_q.push_back('{carry, "R8 delay slot"});
          else if (i <= SW)  exp_q.push_back('{w[SW-i], (i == 1) ? "R5 msb second slot" : tag});
          else               exp_q.push_back('{1'b0, "R7 fill"});
        end
      end
      carry = (fmt_i2s && half == SW) ? w[0] : 1'b0;
    end
    for (int h = 0; h < 2; h++) begin
      for (int i = 0; i < half; i++) begin
        logic lr;
        lr = (h == 0) ? left_lv : ~left_lv;
        if (h == 0 && i == 5 && nstrobe >= 1)      slot(lr, 1, l1, r1);
        else if (h == 1 && i == 3 && nstrobe >= 2) slot(lr, 1, l2, r2);
        else                                       slot(lr, 0, '0, '0);
      end
    end
    if (nstrobe == 1) begin mod_l = l1; mod_r = r1; end
    if (nstrobe >= 2) begin mod_l = l2; mod_r = r2; end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // I2S strapped by pull-up
    do_reset(1);
    frame(64, "R2 i2s framing", 1, 24'h800001, 24'h7FFFFF, '0, '0);
    frame(64, "R1", 1, 24'hA5C30F, 24'h3C5A96, '0, '0);
    frame(64, "R9 mid-frame strobe", 2, 24'h111111, 24'h222222, 24'hFEDCBA, 24'h012345);
    frame(64, "R10 last strobe wins", 0, '0, '0, '0, '0);
    frame(48, "R8 short frame", 1, 24'h000001, 24'hFFFFFF, '0, '0);
    frame(48, "R8 short frame", 1, 24'hC00003, 24'h5AA5A5, '0, '0);
    frame(64, "R8 carry into long", 0, '0, '0, '0, '0);
    frame(64, "R10 repeat", 0, '0, '0, '0, '0);
    check("R1 queue drained", exp_q.size() == 0, 1'b1);

    // left-justified strapped by pull-down
    do_reset(0);
    frame(64, "R2 lj framing", 1, 24'h7FFFFF, 24'h800000, '0, '0);
    frame(64, "R4", 1, 24'h96A50F, 24'h0F0F0F, '0, '0);
    frame(48, "R9 mid-frame strobe", 2, 24'h333333, 24'h444444, 24'hABCDEF, 24'h000001);
    frame(48, "R10 last strobe wins", 0, '0, '0, '0, '0);
    frame(64, "R1", 0, '0, '0, '0, '0);
    check("R1 queue drained", exp_q.size() == 0, 1'b1);

    mon_en = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule